// File: doc/BRIEF.md
# Rotating-Priority Interrupt Controller

This block gathers 64 interrupt request lines into eight outputs: a normal interrupt line, a fast interrupt line and six auxiliary lines. Each source has its own control byte on a simple 32-bit register bus with byte-write strobes. The byte enables the source, picks how it triggers (active-high level, rising edge, falling edge, or both edges) and names the output that it drives. A source in an edge mode keeps a latch that holds the event until software clears it with a write-one-to-clear to one of two status words.

The normal and fast outputs each have a priority register. A read of that register returns the index of the winning pending source routed to that output. The winner is the lowest-numbered source under fixed priority. Under rotating priority, the search starts one above the source that was last reported. When nothing is pending the index reads 63. Software tells this apart from a real request on source 63 by checking bit 31 of the upper status word.

Bus reads are combinational within the access cycle. Writes, and the side effect of a priority read, take effect at the rising clock edge of the access cycle.

Top module: `rot_intc`

## Requirements
- R1: After reset every control byte reads 0, both status words read 0, all outputs are low, and both priority registers read 0x3F (index 63, rotate bit 0).
- R2: The control byte of source n is byte lane n%4 of the word at byte offset 0x40 + n. Bits [2:0] are the destination, bit 3 is the enable, bit 5 selects rising edge and bit 6 selects falling edge. Bits 4 and 7 read 0. A write changes only the lanes whose byte strobe is set.
- R3: A source whose enable bit is 0 is never pending, whatever its input does. It drives no output, and its status bit reads 0.
- R4: With bits 5 and 6 both 0, an enabled source is pending exactly while its input is high. It keeps no latch, so its request drops in the same cycle that the input falls.
- R5: With bit 5 set, an input seen low at one clock edge and high at the next sets the source's latch. The latch holds after the input falls.
- R6: With bit 6 set, an input seen high at one clock edge and low at the next sets the latch. A rising input does not set it while bit 5 is clear.
- R7: Bit n%32 of the status word at 0x80 (sources 0 to 31) or 0x84 (sources 32 to 63) reads the pending state of source n. Writing 1 to a bit under a set byte strobe clears that latch. Writing 0, or writing a 1 under a clear strobe, leaves the latch as it is. A new edge in the same cycle wins over a clear.
- R8: Destination code 0 drives irq_o, code 1 drives fiq_o, and codes 2 to 7 drive aux_o[0] to aux_o[5]. Each output is high exactly while at least one pending source carries its code.
- R9: With the rotate bit clear, bits [5:0] of the register at 0x20 (irq) or 0x24 (fiq) read the lowest-numbered pending source routed to that output.
- R10: With nothing pending on an output, its priority index reads 63. A real request on source 63 also reads 63, and only then does bit 31 of the word at 0x84 read 1.
- R11: Bit 6 of a priority register sets rotating priority and reads back. Under rotation, the winner is the lowest pending index above the last reported index, wrapping to the lowest pending index. The last reported index is updated by every read of that register that finds something pending.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_i | input | 64 | Interrupt request inputs |
| req_i | input | 1 | Bus access valid this cycle |
| we_i | input | 1 | 1 for a write, 0 for a read |
| addr_i | input | 6 | Word address (byte address bits [7:2]) |
| be_i | input | 4 | Byte write strobes |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid in the access cycle |
| irq_o | output | 1 | Normal interrupt output |
| fiq_o | output | 1 | Fast interrupt output |
| aux_o | output | 6 | Auxiliary interrupt outputs |

## Verification
The bench sweeps all 64 sources through level mode, each routed to a different destination in turn, and compares the output one-hot, the status bit and the priority index. A wrong lane or bit decode would light the wrong output or index. A fixed-priority sweep raises every suffix of the source vector, and a design with the search reversed or off by one reports the wrong index. Rotation is driven through a full wrap of all 64 sources and through a sparse pattern, which catches a pointer that fails to advance, advances on empty reads, or never wraps. The edge tests cover a latch that follows the input instead of holding it, the opposite edge setting a latch by mistake, writes of zero that clear, a strobe that is ignored, and index 63 being reported without bit 31 of the upper status word.

// File: rtl/rot_intc_pkg.sv
package rot_intc_pkg;

  localparam int unsigned DEST_W   = 3;
  localparam int unsigned NUM_DEST = 8;
  localparam int unsigned NUM_AUX  = NUM_DEST - 2;

  // word addresses (byte offset >> 2)
  localparam int unsigned PRIO_IRQ_W = 'h20 >> 2;
  localparam int unsigned PRIO_FIQ_W = 'h24 >> 2;
  localparam int unsigned CTRL_W0    = 'h40 >> 2;
  localparam int unsigned STAT_W0    = 'h80 >> 2;

  localparam int unsigned PRIO_ROT_BIT = 6;
  localparam int unsigned CTL_EN_BIT   = 3;
  localparam int unsigned CTL_RISE_BIT = 5;
  localparam int unsigned CTL_FALL_BIT = 6;

  typedef enum logic [DEST_W-1:0] {
    DST_IRQ  = 3'd0,
    DST_FIQ  = 3'd1,
    DST_AUX0 = 3'd2,
    DST_AUX1 = 3'd3,
    DST_AUX2 = 3'd4,
    DST_AUX3 = 3'd5,
    DST_AUX4 = 3'd6,
    DST_AUX5 = 3'd7
  } dest_e;

  typedef struct packed {
    logic              fall;
    logic              rise;
    logic              en;
    logic [DEST_W-1:0] dest;
  } src_cfg_t;

  function automatic logic [7:0] cfg_to_byte(src_cfg_t c);
    logic [7:0] b;
    b = '0;
    b[DEST_W-1:0]   = c.dest;
    b[CTL_EN_BIT]   = c.en;
    b[CTL_RISE_BIT] = c.rise;
    b[CTL_FALL_BIT] = c.fall;
    return b;
  endfunction

endpackage

// File: rtl/intc_src_cell.sv
module intc_src_cell
  import rot_intc_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              src_i,
  input  logic              cfg_we_i,
  input  src_cfg_t          cfg_i,
  input  logic              clr_i,
  output src_cfg_t          cfg_o,
  output logic              pend_o
);

  src_cfg_t cfg_q;
  logic     prev_q;
  logic     latch_q;
  logic     edge_mode;
  logic     hit;

  assign edge_mode = cfg_q.rise | cfg_q.fall;
  assign hit = cfg_q.en & ((cfg_q.rise & src_i & ~prev_q) |
                           (cfg_q.fall & ~src_i & prev_q));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= '0;
    end else if (cfg_we_i) begin
      cfg_q <= cfg_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= 1'b0;
    end else begin
      prev_q <= src_i;
    end
  end

  // new event wins over a clear in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      latch_q <= 1'b0;
    end else if (!(cfg_q.en && edge_mode)) begin
      latch_q <= 1'b0;
    end else if (hit) begin
      latch_q <= 1'b1;
    end else if (clr_i) begin
      latch_q <= 1'b0;
    end
  end

  assign cfg_o  = cfg_q;
  assign pend_o = cfg_q.en & (edge_mode ? latch_q : src_i);

endmodule

// File: rtl/intc_prio_pick.sv
module intc_prio_pick #(
  parameter int unsigned N     = 64,
  localparam int unsigned IDX_W = $clog2(N)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N-1:0]     req_i,
  input  logic             rot_i,
  input  logic             take_i,
  output logic [IDX_W-1:0] idx_o,
  output logic             any_o
);

  logic [IDX_W-1:0] last_q;
  logic [N-1:0]     above;
  logic [N-1:0]     upper;

  function automatic logic [IDX_W-1:0] lowest(logic [N-1:0] v);
    logic [IDX_W-1:0] r;
    r = IDX_W'(N - 1);
    for (int i = N - 1; i >= 0; i--) begin
      if (v[i]) r = IDX_W'(i);
    end
    return r;
  endfunction

  always_comb begin
    for (int i = 0; i < N; i++) begin
      above[i] = (IDX_W'(i) > last_q);
    end
  end

  assign upper = req_i & above;
  assign any_o = |req_i;

  always_comb begin
    if (rot_i && (|upper)) idx_o = lowest(upper);
    else                   idx_o = lowest(req_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      last_q <= IDX_W'(N - 1);
    end else if (take_i && any_o) begin
      last_q <= idx_o;
    end
  end

endmodule

// File: rtl/rot_intc.sv
module rot_intc
  import rot_intc_pkg::*;
#(
  parameter int unsigned NUM_SRC = 64,
  parameter int unsigned ADDR_W  = 8,
  localparam int unsigned IDX_W      = $clog2(NUM_SRC),
  localparam int unsigned WORD_W     = ADDR_W - 2,
  localparam int unsigned CTRL_WORDS = NUM_SRC / 4,
  localparam int unsigned STAT_WORDS = NUM_SRC / 32
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_SRC-1:0]  src_i,
  input  logic                req_i,
  input  logic                we_i,
  input  logic [ADDR_W-1:2]   addr_i,
  input  logic [3:0]          be_i,
  input  logic [31:0]         wdata_i,
  output logic [31:0]         rdata_o,
  output logic                irq_o,
  output logic                fiq_o,
  output logic [NUM_AUX-1:0]  aux_o
);

  logic                 wr;
  logic                 rd;
  logic [NUM_SRC-1:0]   cfg_we;
  logic [NUM_SRC-1:0]   clr;
  logic [NUM_SRC-1:0]   pend;
  src_cfg_t             cfg   [NUM_SRC];
  logic [NUM_SRC*8-1:0] cfg_flat;
  logic [NUM_SRC-1:0]   dest_req [NUM_DEST];
  logic [NUM_DEST-1:0]  out_any;
  logic [NUM_SRC-1:0]   irq_req;
  logic [NUM_SRC-1:0]   fiq_req;
  logic                 irq_rot_q;
  logic                 fiq_rot_q;
  logic [IDX_W-1:0]     irq_idx;
  logic [IDX_W-1:0]     fiq_idx;
  logic                 irq_any;
  logic                 fiq_any;
  logic                 irq_take;
  logic                 fiq_take;

  assign wr = req_i & we_i;
  assign rd = req_i & ~we_i;

  // per-source cells
  for (genvar n = 0; n < NUM_SRC; n++) begin : g_src
    localparam int unsigned LANE  = n % 4;
    localparam int unsigned SWORD = n / 32;
    localparam int unsigned SBIT  = n % 32;
    src_cfg_t cin;
    logic [7:0] wb;

    assign wb  = wdata_i[LANE*8 +: 8];
    assign cin = '{fall: wb[CTL_FALL_BIT], rise: wb[CTL_RISE_BIT],
                   en: wb[CTL_EN_BIT], dest: wb[DEST_W-1:0]};

    assign cfg_we[n] = wr && (addr_i == WORD_W'(CTRL_W0 + n / 4)) && be_i[LANE];
    assign clr[n]    = wr && (addr_i == WORD_W'(STAT_W0 + SWORD)) &&
                       be_i[SBIT / 8] && wdata_i[SBIT];

    intc_src_cell u_cell (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .src_i    (src_i[n]),
      .cfg_we_i (cfg_we[n]),
      .cfg_i    (cin),
      .clr_i    (clr[n]),
      .cfg_o    (cfg[n]),
      .pend_o   (pend[n])
    );

    assign cfg_flat[n*8 +: 8] = cfg_to_byte(cfg[n]);
  end

  // routing
  for (genvar d = 0; d < NUM_DEST; d++) begin : g_dest
    always_comb begin
      for (int n = 0; n < NUM_SRC; n++) begin
        dest_req[d][n] = pend[n] && (cfg[n].dest == DEST_W'(d));
      end
    end
    assign out_any[d] = |dest_req[d];
  end

  assign irq_req = dest_req[DST_IRQ];
  assign fiq_req = dest_req[DST_FIQ];
  assign irq_o   = out_any[DST_IRQ];
  assign fiq_o   = out_any[DST_FIQ];
  assign aux_o   = out_any[NUM_DEST-1:DST_AUX0];

  // priority control
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_rot_q <= 1'b0;
      fiq_rot_q <= 1'b0;
    end else if (wr && be_i[0]) begin
      if (addr_i == WORD_W'(PRIO_IRQ_W)) irq_rot_q <= wdata_i[PRIO_ROT_BIT];
      if (addr_i == WORD_W'(PRIO_FIQ_W)) fiq_rot_q <= wdata_i[PRIO_ROT_BIT];
    end
  end

  assign irq_take = rd && (addr_i == WORD_W'(PRIO_IRQ_W));
  assign fiq_take = rd && (addr_i == WORD_W'(PRIO_FIQ_W));

  intc_prio_pick #(.N(NUM_SRC)) u_irq_pick (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .req_i  (irq_req),
    .rot_i  (irq_rot_q),
    .take_i (irq_take),
    .idx_o  (irq_idx),
    .any_o  (irq_any)
  );

  intc_prio_pick #(.N(NUM_SRC)) u_fiq_pick (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .req_i  (fiq_req),
    .rot_i  (fiq_rot_q),
    .take_i (fiq_take),
    .idx_o  (fiq_idx),
    .any_o  (fiq_any)
  );

  // read mux
  always_comb begin
    rdata_o = '0;
    if (addr_i == WORD_W'(PRIO_IRQ_W)) begin
      rdata_o[IDX_W-1:0]    = irq_idx;
      rdata_o[PRIO_ROT_BIT] = irq_rot_q;
    end
    if (addr_i == WORD_W'(PRIO_FIQ_W)) begin
      rdata_o[IDX_W-1:0]    = fiq_idx;
      rdata_o[PRIO_ROT_BIT] = fiq_rot_q;
    end
    for (int k = 0; k < CTRL_WORDS; k++) begin
      if (addr_i == WORD_W'(CTRL_W0 + k)) rdata_o = cfg_flat[k*32 +: 32];
    end
    for (int k = 0; k < STAT_WORDS; k++) begin
      if (addr_i == WORD_W'(STAT_W0 + k)) rdata_o = pend[k*32 +: 32];
    end
  end

endmodule

// File: rtl/rot_intc_chk.sv
module rot_intc_chk
  import rot_intc_pkg::*;
#(
  parameter int unsigned NUM_SRC = 64,
  parameter int unsigned ADDR_W  = 8,
  localparam int unsigned IDX_W  = $clog2(NUM_SRC),
  localparam int unsigned WORD_W = ADDR_W - 2
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               req_i,
  input logic               we_i,
  input logic [ADDR_W-1:2]  addr_i,
  input logic [31:0]        rdata_o,
  input logic [NUM_SRC-1:0] irq_req,
  input logic [IDX_W-1:0]   irq_idx,
  input logic               irq_any,
  input logic               irq_rot_q,
  input logic [IDX_W-1:0]   fiq_idx,
  input logic               fiq_any
);

  logic [NUM_SRC-1:0] irq_below;
  logic               rd_ctrl;
  logic               rd_prio;
  logic               wr_irq_prio;

  assign irq_below   = (NUM_SRC'(1) << irq_idx) - NUM_SRC'(1);
  assign rd_ctrl     = req_i && !we_i && (addr_i >= WORD_W'(CTRL_W0)) &&
                       (addr_i < WORD_W'(CTRL_W0 + NUM_SRC / 4));
  assign rd_prio     = req_i && !we_i && ((addr_i == WORD_W'(PRIO_IRQ_W)) ||
                                          (addr_i == WORD_W'(PRIO_FIQ_W)));
  assign wr_irq_prio = req_i && we_i && (addr_i == WORD_W'(PRIO_IRQ_W));

  a_r10_irq_idle_top: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_any |-> irq_idx == IDX_W'(NUM_SRC - 1));

  a_r10_fiq_idle_top: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fiq_any |-> fiq_idx == IDX_W'(NUM_SRC - 1));

  a_r9_winner_pending: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_any |-> irq_req[irq_idx]);

  a_r9_fixed_lowest: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_any && !irq_rot_q) |-> ((irq_req & irq_below) == '0));

  a_r2_ctrl_rsvd_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_ctrl |-> ((rdata_o & 32'h9090_9090) == 32'h0));

  a_r11_prio_upper_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_prio |-> (rdata_o[31:7] == 25'h0));

  a_r11_rot_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_irq_prio |=> $stable(irq_rot_q));

endmodule

bind rot_intc rot_intc_chk #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .req_i     (req_i),
  .we_i      (we_i),
  .addr_i    (addr_i),
  .rdata_o   (rdata_o),
  .irq_req   (irq_req),
  .irq_idx   (irq_idx),
  .irq_any   (irq_any),
  .irq_rot_q (irq_rot_q),
  .fiq_idx   (fiq_idx),
  .fiq_any   (fiq_any)
);

// File: tb/rot_intc_tb_top.sv
module rot_intc_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] src = '0;
  logic        req = 1'b0;
  logic        we = 1'b0;
  logic [7:0]  addr = '0;
  logic [3:0]  be = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq, fiq;
  logic [5:0]  aux;

  int n_tests = 0;
  int n_fail  = 0;

  always #5 clk = ~clk;

  rot_intc dut_i (
    .clk_i   (clk),
    .rst_ni  (rst_n),
    .src_i   (src),
    .req_i   (req),
    .we_i    (we),
    .addr_i  (addr[7:2]),
    .be_i    (be),
    .wdata_i (wdata),
    .rdata_o (rdata),
    .irq_o   (irq),
    .fiq_o   (fiq),
    .aux_o   (aux)
  );

  function automatic logic [7:0] outs();
    return {aux, fiq, irq};
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [7:0] a, input logic [31:0] d, input logic [3:0] b);
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = a; wdata = d; be = b;
    @(negedge clk);
    req = 1'b0; we = 1'b0; be = '0;
    #1;
  endtask

  task automatic bus_rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b0; addr = a;
    #1 d = rdata;
    @(negedge clk);
    req = 1'b0;
    #1;
  endtask

  task automatic set_ctrl(input int n, input logic [7:0] v);
    bus_wr(8'(8'h40 + (n & ~3)), 32'(v) << (8 * (n % 4)), 4'(1 << (n % 4)));
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run did not finish");
    summary();
    $finish;
  end

  initial begin
    logic [31:0] r;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    #1;

    // R1 reset state
    chk("R1 outputs", 64'(outs()), 64'h0);
    for (int k = 0; k < 16; k++) begin
      bus_rd(8'(8'h40 + 4 * k), r);
      chk("R1 ctrl word", 64'(r), 64'h0);
    end
    bus_rd(8'h20, r); chk("R1 irq prio", 64'(r), 64'h3F);
    bus_rd(8'h24, r); chk("R1 fiq prio", 64'(r), 64'h3F);
    bus_rd(8'h80, r); chk("R1 stat lo", 64'(r), 64'h0);
    bus_rd(8'h84, r); chk("R1 stat hi", 64'(r), 64'h0);

    // R3 disabled sources ignore inputs
    @(negedge clk) src = '1;
    @(negedge clk) src = '0;
    @(negedge clk) src = '1;
    #1 chk("R3 outputs", 64'(outs()), 64'h0);
    bus_rd(8'h80, r); chk("R3 stat lo", 64'(r), 64'h0);
    bus_rd(8'h84, r); chk("R3 stat hi", 64'(r), 64'h0);
    bus_rd(8'h20, r); chk("R3 prio", 64'(r), 64'h3F);
    @(negedge clk) src = '0;

    // R4 / R8 / R9 level sweep, destination n%8
    for (int n = 0; n < 64; n++) begin
      set_ctrl(n, 8'(8'h08 | (n % 8)));
      chk("R4 idle", 64'(outs()), 64'h0);
      @(negedge clk) src[n] = 1'b1;
      #1 chk("R8 routing", 64'(outs()), 64'(1 << (n % 8)));
      if (n % 8 < 2) begin
        bus_rd((n % 8 == 0) ? 8'h20 : 8'h24, r);
        chk("R9 single index", 64'(r), 64'(n));
      end
      bus_rd(8'(8'h80 + 4 * (n / 32)), r);
      chk("R7 stat bit", 64'(r), 64'(32'(1) << (n % 32)));
      @(negedge clk) src[n] = 1'b0;
      #1 chk("R4 no latch", 64'(outs()), 64'h0);
      set_ctrl(n, 8'h00);
    end

    // R2 field readback and byte strobes
    set_ctrl(5, 8'hFF);
    bus_rd(8'h44, r); chk("R2 byte lane", 64'(r), 64'h0000_6F00);
    set_ctrl(5, 8'h00);
    bus_rd(8'h44, r); chk("R2 cleared", 64'(r), 64'h0);

    // R5 rising edge, source 40 to fiq
    set_ctrl(40, 8'h29);
    @(negedge clk) src[40] = 1'b1;
    @(negedge clk) #1 chk("R5 rise sets", 64'(fiq), 64'h1);
    @(negedge clk) src[40] = 1'b0;
    @(negedge clk) #1 chk("R5 held", 64'(fiq), 64'h1);
    bus_rd(8'h84, r); chk("R7 stat edge", 64'(r), 64'h100);
    bus_wr(8'h84, 32'h100, 4'b0010);
    chk("R7 w1c clears", 64'(fiq), 64'h0);
    @(negedge clk) #1 chk("R5 fall ignored", 64'(fiq), 64'h0);

    // R6 falling edge, source 7 to aux3
    set_ctrl(7, 8'h4D);
    @(negedge clk) src[7] = 1'b1;
    @(negedge clk) #1 chk("R6 rise ignored", 64'(aux), 64'h0);
    @(negedge clk) src[7] = 1'b0;
    @(negedge clk) #1 chk("R6 fall sets", 64'(aux), 64'h08);
    bus_wr(8'h80, 32'h0, 4'hF);
    chk("R7 zero write", 64'(aux), 64'h08);
    bus_wr(8'h80, 32'h80, 4'b1110);
    chk("R7 strobe off", 64'(aux), 64'h08);
    bus_wr(8'h80, 32'h80, 4'b0001);
    chk("R7 strobe on", 64'(aux), 64'h0);
    set_ctrl(7, 8'h00);
    set_ctrl(40, 8'h00);

    // R9 fixed priority over every suffix, all level to irq
    for (int k = 0; k < 16; k++) bus_wr(8'(8'h40 + 4 * k), 32'h0808_0808, 4'hF);
    for (int k = 0; k < 64; k++) begin
      @(negedge clk) src = ~64'h0 << k;
      bus_rd(8'h20, r);
      chk("R9 lowest wins", 64'(r), 64'(k));
    end

    // R10 index 63 ambiguity
    @(negedge clk) src = 64'h1 << 63;
    bus_rd(8'h20, r); chk("R10 real 63", 64'(r), 64'h3F);
    bus_rd(8'h84, r); chk("R10 bit31 set", 64'(r[31]), 64'h1);
    @(negedge clk) src = '0;
    bus_rd(8'h20, r); chk("R10 idle 63", 64'(r), 64'h3F);
    bus_rd(8'h84, r); chk("R10 bit31 clear", 64'(r[31]), 64'h0);

    // R11 rotating priority
    bus_wr(8'h20, 32'h40, 4'h1);
    bus_rd(8'h20, r); chk("R11 rot readback", 64'(r), 64'h7F);
    bus_rd(8'h24, r); chk("R11 fiq untouched", 64'(r), 64'h3F);
    @(negedge clk) src = (64'h1 << 3) | (64'h1 << 10) | (64'h1 << 40);
    bus_rd(8'h20, r); chk("R11 rot first", 64'(r), 64'h43);
    bus_rd(8'h20, r); chk("R11 rot second", 64'(r), 64'h4A);
    bus_rd(8'h20, r); chk("R11 rot third", 64'(r), 64'h68);
    bus_rd(8'h20, r); chk("R11 rot wrap", 64'(r), 64'h43);
    @(negedge clk) src = '1;
    for (int i = 0; i < 65; i++) begin
      bus_rd(8'h20, r);
      chk("R11 rot sweep", 64'(r), 64'(32'h40 | ((4 + i) % 64)));
    end
    bus_wr(8'h20, 32'h0, 4'h1);
    @(negedge clk) src = (64'h1 << 3) | (64'h1 << 10);
    bus_rd(8'h20, r); chk("R11 fixed again", 64'(r), 64'h03);
    bus_rd(8'h20, r); chk("R11 fixed repeat", 64'(r), 64'h03);
    @(negedge clk) src = '0;

    summary();
    $finish;
  end

endmodule